// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is a system timer for an operating system. One counter, 32 bits wide, counts up once for each cycle in which `tick_en` is high. It runs through its whole range and wraps to zero. Four compare registers sit beside the counter. Each cycle in which a tick moves the counter onto a compare value, that channel's pending flag is latched. The flag drives the channel's interrupt line only while the channel's enable bit is set.

A compare never stops or reloads the counter. Software makes a periodic tick by rewriting the compare register with the current count plus the period after each hit. Channel 3 has a second job. While the watchdog is armed, a hit on channel 3 also sends out a one-clock system reset pulse.

All state is reached through a plain 32-bit register port with byte addresses. The port has a write strobe and a combinational read. There are eight word registers:

| Offset | Register |
|---|---|
| 0x00, 0x04, 0x08, 0x0C | compare values for channels 0 to 3 |
| 0x10 | counter |
| 0x14 | pending flags |
| 0x18 | watchdog arm |
| 0x1C | interrupt enables |

Top module: `match_timer`

## Requirements
- R1: The counter at 0x10 adds one at each clock edge where `tick_en` is high and no counter write is made. It holds its value when `tick_en` is low, and it wraps from 0xFFFFFFFF to 0.
- R2: A write to 0x10 loads `wdata` into the counter at that edge, and this write takes precedence over a tick in the same cycle. Counting then goes on from the loaded value.
- R3: The compare registers at 0x00, 0x04, 0x08 and 0x0C (channels 0 to 3) read back what was last written. When a tick moves the counter onto a channel's compare value, that channel's pending bit (bit i of 0x14) is set at the same edge. The counter keeps counting afterwards.
- R4: Writing 0x14 clears each pending bit whose `wdata` bit is 1 and leaves bits written with 0 unchanged. If a hit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Bits 3:0 of 0x1C enable channels 0 to 3, and the upper bits read as zero. `irq[i]` is high exactly when pending bit i and enable bit i are both 1.
- R6: Bit 0 of 0x18 arms the watchdog, and the upper bits read as zero. While it is armed, a channel 3 hit drives `sys_rst` high for the single clock that follows the hit edge. While it is disarmed, `sys_rst` stays low.
- R7: After reset, all eight registers read zero, and `irq` and `sys_rst` are low.
- R8: Loading the counter directly with a compare value by a write does not set that channel's pending bit. Only a tick onto the value does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| sys_rst | output | 1 | Watchdog system reset pulse |

## Verification
Random phases mix register writes with `tick_en` held high about 70% of the time. Compare values are placed a few counts ahead of the counter, so hits come often. Their timing tests that a hit needs a tick and is tied to the counter's next value. Pending clears land at random, which exercises a clear racing a hit.

Directed cases check:
- the wrap from 0xFFFFFFFF onto a compare value of 0,
- a counter write together with a tick,
- a counter written straight onto a compare value, which must not hit,
- a clear in the same cycle as a hit,
- channel 3 hits with the watchdog armed and with it disarmed.

// File: rtl/mt_pkg.sv
package mt_pkg;
    // Register word indices (byte address bits [4:2])
    localparam logic [2:0] IDX_CNT  = 3'd4;
    localparam logic [2:0] IDX_PEND = 3'd5;
    localparam logic [2:0] IDX_WDOG = 3'd6;
    localparam logic [2:0] IDX_IEN  = 3'd7;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_inc,
    output logic         adv
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign cnt_inc = st_q.cnt + 1'b1;
    assign adv     = tick_en && !load;
    assign cnt_q   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick_en) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    input  logic         adv,
    input  logic [W-1:0] cnt_inc,
    input  logic         clr,
    input  logic         ien,
    output logic [W-1:0] cmp_q,
    output logic         hit,
    output logic         pend_q,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic         pend;
    } ch_state_t;

    ch_state_t st_d, st_q;

    assign hit    = adv && (cnt_inc == st_q.cmp);
    assign cmp_q  = st_q.cmp;
    assign pend_q = st_q.pend;
    assign irq    = st_q.pend && ien;

    always_comb begin
        st_d = st_q;
        if (wr_cmp) begin
            st_d.cmp = wdata;
        end
        // set has priority over a clear in the same cycle
        st_d.pend = (st_q.pend && !clr) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mt_wdog.sv
module mt_wdog (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_arm,
    input  logic arm_val,
    input  logic wd_hit,
    output logic armed_q,
    output logic sys_rst
);
    typedef struct packed {
        logic armed;
        logic rst;
    } wd_state_t;

    wd_state_t st_d, st_q;

    assign armed_q = st_q.armed;
    assign sys_rst = st_q.rst;

    always_comb begin
        st_d = st_q;
        st_d.rst = st_q.armed && wd_hit;
        if (wr_arm) begin
            st_d.armed = arm_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int DATA_W = 32,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 5,
    parameter int WD_CH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_CH-1:0]   irq,
    output logic              sys_rst
);
    import mt_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [N_CH-1:0] ien;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [IDX_W-1:0]  widx;
    logic              wr_cnt;
    logic              wr_pend;
    logic              wr_wd;
    logic              wr_ien;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_inc;
    logic              adv;
    logic [N_CH-1:0]   hit;
    logic [N_CH-1:0]   pend_q;
    logic [DATA_W-1:0] cmp_q [N_CH];
    logic              armed_q;

    assign widx    = addr[ADDR_W-1:2];
    assign wr_cnt  = wr_en && (widx == IDX_CNT);
    assign wr_pend = wr_en && (widx == IDX_PEND);
    assign wr_wd   = wr_en && (widx == IDX_WDOG);
    assign wr_ien  = wr_en && (widx == IDX_IEN);

    mt_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_cnt),
        .load_val (wdata),
        .cnt_q    (cnt_q),
        .cnt_inc  (cnt_inc),
        .adv      (adv)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        mt_channel #(.W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cmp  (wr_en && (widx == IDX_W'(c))),
            .wdata   (wdata),
            .adv     (adv),
            .cnt_inc (cnt_inc),
            .clr     (wr_pend && wdata[c]),
            .ien     (st_q.ien[c]),
            .cmp_q   (cmp_q[c]),
            .hit     (hit[c]),
            .pend_q  (pend_q[c]),
            .irq     (irq[c])
        );
    end

    mt_wdog u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_arm  (wr_wd),
        .arm_val (wdata[0]),
        .wd_hit  (hit[WD_CH]),
        .armed_q (armed_q),
        .sys_rst (sys_rst)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ien) begin
            st_d.ien = wdata[N_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (widx)
            IDX_CNT:  rdata = cnt_q;
            IDX_PEND: rdata[N_CH-1:0] = pend_q;
            IDX_WDOG: rdata[0] = armed_q;
            IDX_IEN:  rdata[N_CH-1:0] = st_q.ien;
            default: begin
                for (int c = 0; c < N_CH; c++) begin
                    if (widx == IDX_W'(c)) rdata = cmp_q[c];
                end
            end
        endcase
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int DATA_W = 32,
    parameter int N_CH   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_cnt,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] cmp0,
    input logic [N_CH-1:0]   pend_q,
    input logic [N_CH-1:0]   ien,
    input logic [N_CH-1:0]   irq,
    input logic              armed_q,
    input logic              sys_rst
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_cnt) |=> $stable(cnt_q)); // R1
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata))); // R2
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_cnt && (cnt_q + 1'b1 == cmp0)) |=> pend_q[0]); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~(pend_q & ien)) == '0)); // R5
    AST_WD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> ($past(armed_q) && pend_q[N_CH-1])); // R6
    AST_WD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst); // R6
endmodule

bind match_timer mt_checker #(.DATA_W(DATA_W), .N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_cnt  (wr_cnt),
    .wdata   (wdata),
    .cnt_q   (cnt_q),
    .cmp0    (cmp_q[0]),
    .pend_q  (pend_q),
    .ien     (st_q.ien),
    .irq     (irq),
    .armed_q (armed_q),
    .sys_rst (sys_rst)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_en = 0;
    logic        wr_en = 0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        sys_rst;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_cnt;
    logic [31:0] m_cmp [4];
    logic [3:0]  m_pend;
    logic [3:0]  m_ien;
    logic        m_wd;
    logic        m_rst;

    always #2.5 clk = ~clk;

    match_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] idx);
        case (idx)
            3'd4: return m_cnt;
            3'd5: return {28'd0, m_pend};
            3'd6: return {31'd0, m_wd};
            3'd7: return {28'd0, m_ien};
            default: return m_cmp[idx[1:0]];
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] idx);
        case (idx)
            3'd4: return "R1";
            3'd5: return "R4";
            3'd6: return "R6";
            3'd7: return "R5";
            default: return "R3";
        endcase
    endfunction

    // one clock: drive at negedge, update model at edge, compare outputs
    task automatic step(input bit wr, input logic [2:0] idx, input logic [31:0] d, input bit tk);
        logic [3:0] hit;
        bit cw;
        wr_en = wr; addr = {idx, 2'b00}; wdata = d; tick_en = tk;
        @(posedge clk);
        cw = wr && idx == 3'd4;
        for (int c = 0; c < 4; c++) hit[c] = tk && !cw && (m_cnt + 1 == m_cmp[c]);
        m_rst = m_wd && hit[3];
        if (cw) m_cnt = d; else if (tk) m_cnt = m_cnt + 1;
        if (wr && idx < 3'd4) m_cmp[idx[1:0]] = d;
        m_pend = (m_pend & ~((wr && idx == 3'd5) ? d[3:0] : 4'h0)) | hit;
        if (wr && idx == 3'd6) m_wd = d[0];
        if (wr && idx == 3'd7) m_ien = d[3:0];
        @(negedge clk);
        wr_en = 0; tick_en = 0;
        check("R5", {28'd0, irq}, {28'd0, m_pend & m_ien});
        check("R6", {31'd0, sys_rst}, {31'd0, m_rst});
    endtask

    task automatic rd(input logic [2:0] idx, input string tag);
        addr = {idx, 2'b00};
        #1;
        check(tag, rdata, exp_read(idx));
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] base;
        void'($urandom(1234));
        m_cnt = 0; m_pend = 0; m_ien = 0; m_wd = 0; m_rst = 0;
        for (int c = 0; c < 4; c++) m_cmp[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        for (int i = 0; i < 8; i++) rd(3'(i), "R7");
        check("R7", {27'd0, irq, sys_rst}, 32'd0);

        // R1 count and wrap onto compare 0
        step(1, 3'd4, 32'hFFFF_FFFE, 0);
        step(1, 3'd0, 32'h0, 0);
        step(1, 3'd7, 32'hF, 0);
        step(0, 3'd0, 0, 1);
        rd(3'd4, "R1");
        step(0, 3'd0, 0, 1);
        rd(3'd4, "R1");
        rd(3'd5, "R3");
        step(0, 3'd0, 0, 0);
        rd(3'd4, "R1");
        step(0, 3'd0, 0, 1);
        rd(3'd4, "R3");

        // R2 write beats tick
        step(1, 3'd4, 32'h0000_1000, 1);
        rd(3'd4, "R2");
        step(0, 3'd0, 0, 1);
        rd(3'd4, "R2");

        // R8 direct load onto compare value
        step(1, 3'd5, 32'hF, 0);
        step(1, 3'd1, 32'h0000_2000, 0);
        step(1, 3'd4, 32'h0000_2000, 0);
        rd(3'd5, "R8");
        step(0, 3'd0, 0, 1);
        rd(3'd5, "R8");

        // R4 set wins over same-cycle clear
        step(1, 3'd2, 32'h0000_2002, 0);
        step(1, 3'd5, 32'h4, 1);
        rd(3'd5, "R4");
        step(1, 3'd5, 32'h0, 0);
        rd(3'd5, "R4");
        step(1, 3'd5, 32'h4, 0);
        rd(3'd5, "R4");

        // R6 disarmed, then armed
        step(1, 3'd3, 32'h0000_2003, 0);
        step(0, 3'd0, 0, 1);
        rd(3'd5, "R6");
        step(1, 3'd6, 32'hFFFF_FFFF, 0);
        rd(3'd6, "R6");
        step(1, 3'd3, 32'h0000_2005, 0);
        step(0, 3'd0, 0, 1);
        step(0, 3'd0, 0, 1);
        step(0, 3'd0, 0, 0);
        step(1, 3'd6, 32'h0, 0);
        rd(3'd7, "R5");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            logic [2:0] idx;
            logic [31:0] d;
            r = $urandom;
            idx = 3'($urandom_range(0, 7));
            base = m_cnt;
            case (idx)
                3'd4: d = (r[3:0] == 0) ? $urandom : base + $urandom_range(0, 3);
                3'd5: d = $urandom;
                3'd6: d = {31'd0, r[20] & r[21]};
                3'd7: d = $urandom;
                default: d = base + $urandom_range(1, 6);
            endcase
            step(r[9:8] == 2'b00, idx, d, r[19:17] < 3'd6 || r[19:17] == 3'd7 ? (r[5:4] != 0) : 1'b0);
            if (r[31:29] == 3'd0) begin
                logic [2:0] ri;
                ri = 3'($urandom_range(0, 7));
                rd(ri, tag_of(ri));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule